// File: doc/BRIEF.md
# GPIO Event Detector with Grouped Interrupts

This block watches the 54 inputs of a general-purpose I/O port and records events on them. Six enable words select how each pin is watched. Four of the modes work on a synchronized copy of the pin: rising edge, falling edge, high level and low level. The other two modes, rising and falling, work on the raw input, one stage ahead of the synchronizer. Any mix of modes may be enabled on one pin at the same time. A detected event sets that pin's sticky status bit. Software clears the bit by writing a 1 to it.

The status bits are gathered into three interrupt outputs. Each output covers a fixed, contiguous range of pins, and the middle range crosses the boundary between the two 32-bit banks. Software reaches all the words through a plain 32-bit register port: a write strobe, a read strobe, a byte address and data.

All ports are plain control and status pins, so none of them uses a valid/ready handshake. A write takes effect on the clock edge at which it is strobed. Read data appears on the edge after the read strobe and is zero in every other cycle.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset, every status and enable bit is 0, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: Each word is addressed as base + 12·type + 4·bank, where bank 0 holds pins 0–31 and bank 1 holds pins 32–53 in bit positions 0–21. The base is 0x40, and the type order is status, sync rising, sync falling, high, low, async rising, async falling. An enable word reads back what was written, and bank 1 bits 22–31 read 0.
- R3: With sync rising enabled, a 0→1 pad change sets the status bit on the third clock edge after the change, and the interrupt rises on the fourth.
- R4: With both sync rising and sync falling enabled, either edge of the pin sets its status bit.
- R5: With high (low) level enabled, the status bit is set while the synchronized pin is 1 (0). A clear has no lasting effect while the level still holds.
- R6: Async rising/falling detection sets the status bit on the first clock edge after the raw pad change, and the interrupt rises on the second.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a set condition occurs in the same cycle as a clear, the set wins.
- R8: A status bit that was set before its enable was cleared stays set until it is cleared by a status write.
- R9: `irq_o[0]` is the registered OR of pins 0–27, `irq_o[1]` of pins 28–45 and `irq_o[2]` of pins 46–53. Each follows the status one cycle later.
- R10: A pin edge that no enabled mode matches leaves the status unchanged.
- R11: Read data is registered and appears one cycle after the read strobe. Unmapped or misaligned addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | 54 | Raw pin levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 3 | Grouped interrupt lines |

## Verification
Each result has a fixed delay from its stimulus:
- An async event reaches status one edge after the pad changes and the interrupt one edge later.
- The sync edge and level modes need three edges to reach status and four to reach the interrupt.
- A register write acts on its own edge, and the interrupt follows one edge after that.
- Read data follows one edge after the strobe.

The bench drives inputs and samples outputs at falling edges. It counts edges from each stimulus, checks the interrupt lines exactly at these points, and checks just before them where the interrupt must still be low. Each read queues an expected word, and the queued word is compared at the falling edge after the strobed edge.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned NUM_KINDS = 7;
  localparam int unsigned MAP_BASE   = 'h40;
  localparam int unsigned MAP_STRIDE = 12;

  // word types in address order: status first, then the six enables
  typedef enum logic [2:0] {
    K_STAT  = 3'd0,
    K_RISE  = 3'd1,
    K_FALL  = 3'd2,
    K_HIGH  = 3'd3,
    K_LOW   = 3'd4,
    K_ARISE = 3'd5,
    K_AFALL = 3'd6
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    reg_kind_e kind;
    logic [3:0] bank;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr,
                                           input int unsigned banks);
    reg_sel_t s;
    int unsigned a, off, slot;
    s = '0;
    a = 32'(addr);
    if (a >= MAP_BASE && addr[1:0] == 2'b00) begin
      off  = a - MAP_BASE;
      slot = off % MAP_STRIDE;
      if (off < MAP_STRIDE * NUM_KINDS && slot < banks * 4) begin
        s.hit  = 1'b1;
        s.kind = reg_kind_e'(3'(off / MAP_STRIDE));
        s.bank = 4'(slot / 4);
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int unsigned NUM_PINS    = 54,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] cur_o,
  output logic [NUM_PINS-1:0] prev_o,
  output logic [NUM_PINS-1:0] raw_prev_o
);
  logic [NUM_PINS-1:0] stg_q [SYNC_STAGES];
  logic [NUM_PINS-1:0] prev_q, raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      stg_q[0] <= pad_i;
      for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[SYNC_STAGES-1];
      raw_q  <= pad_i;
    end
  end

  assign cur_o      = stg_q[SYNC_STAGES-1];
  assign prev_o     = prev_q;
  assign raw_prev_o = raw_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned NUM_PINS = 54
) (
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] cur_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] raw_prev_i,
  input  logic [NUM_PINS-1:0] en_rise_i,
  input  logic [NUM_PINS-1:0] en_fall_i,
  input  logic [NUM_PINS-1:0] en_high_i,
  input  logic [NUM_PINS-1:0] en_low_i,
  input  logic [NUM_PINS-1:0] en_arise_i,
  input  logic [NUM_PINS-1:0] en_afall_i,
  output logic [NUM_PINS-1:0] set_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic s_up, s_dn, a_up, a_dn;
    assign s_up = cur_i[p] & ~prev_i[p];
    assign s_dn = ~cur_i[p] & prev_i[p];
    assign a_up = pad_i[p] & ~raw_prev_i[p];
    assign a_dn = ~pad_i[p] & raw_prev_i[p];
    assign set_o[p] = (en_rise_i[p]  & s_up)     | (en_fall_i[p]  & s_dn) |
                      (en_high_i[p]  & cur_i[p]) | (en_low_i[p]   & ~cur_i[p]) |
                      (en_arise_i[p] & a_up)     | (en_afall_i[p] & a_dn);
  end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [BUS_W-1:0]    bus_wdata_i,
  output logic [BUS_W-1:0]    bus_rdata_o,
  input  logic [NUM_PINS-1:0] set_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [NUM_PINS-1:0] en_rise_o,
  output logic [NUM_PINS-1:0] en_fall_o,
  output logic [NUM_PINS-1:0] en_high_o,
  output logic [NUM_PINS-1:0] en_low_o,
  output logic [NUM_PINS-1:0] en_arise_o,
  output logic [NUM_PINS-1:0] en_afall_o
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BUS_W - 1) / BUS_W;
  localparam int unsigned PAD_W     = NUM_BANKS * BUS_W;
  localparam int unsigned NUM_EN    = NUM_KINDS - 1;

  reg_sel_t sel;
  logic [PAD_W-1:0] wr_bits, wr_lane, rd_vec;
  logic [NUM_EN-1:0][NUM_PINS-1:0] en_all;
  logic [NUM_PINS-1:0] status_q, clr_vec;
  logic [BUS_W-1:0] rd_word, rdata_q;

  assign sel = decode_addr(bus_addr_i, NUM_BANKS);

  // place the write word on its bank lane
  always_comb begin
    wr_bits = '0;
    wr_lane = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel.bank == 4'(b)) begin
        wr_bits[b*BUS_W +: BUS_W] = bus_wdata_i;
        wr_lane[b*BUS_W +: BUS_W] = '1;
      end
    end
  end

  assign clr_vec = (bus_wr_i && sel.hit && sel.kind == K_STAT) ?
                   wr_bits[NUM_PINS-1:0] : '0;

  for (genvar k = 0; k < NUM_EN; k++) begin : g_en
    logic hit_k;
    logic [NUM_PINS-1:0] q;
    assign hit_k = bus_wr_i && sel.hit && (sel.kind == reg_kind_e'(3'(k + 1)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (hit_k) q <= (q & ~wr_lane[NUM_PINS-1:0]) | wr_bits[NUM_PINS-1:0];
    end
    assign en_all[k] = q;
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_i;
  end

  always_comb begin
    rd_vec = '0;
    if (sel.kind == K_STAT) rd_vec[NUM_PINS-1:0] = status_q;
    for (int k = 0; k < NUM_EN; k++) begin
      if (sel.kind == reg_kind_e'(3'(k + 1))) rd_vec[NUM_PINS-1:0] = en_all[k];
    end
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel.bank == 4'(b)) rd_word = rd_vec[b*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= (bus_rd_i && sel.hit) ? rd_word : '0;
  end

  assign bus_rdata_o = rdata_q;
  assign status_o    = status_q;
  assign clr_o       = clr_vec;
  assign en_rise_o   = en_all[0];
  assign en_fall_o   = en_all[1];
  assign en_high_o   = en_all[2];
  assign en_low_o    = en_all[3];
  assign en_arise_o  = en_all[4];
  assign en_afall_o  = en_all[5];
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
  parameter int unsigned NUM_PINS  = 54,
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned LINE_START [NUM_LINES] = '{0, 28, 46}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  status_i,
  output logic [NUM_LINES-1:0] irq_o
);
  function automatic int unsigned line_end(input int unsigned l);
    if (l + 1 < NUM_LINES) return LINE_START[l+1];
    return NUM_PINS;
  endfunction

  function automatic logic [NUM_PINS-1:0] range_mask(input int unsigned lo,
                                                     input int unsigned hi);
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_PINS; i++) m[i] = (i >= lo) && (i < hi);
    return m;
  endfunction

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam logic [NUM_PINS-1:0] MASK = range_mask(LINE_START[l], line_end(l));
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= |(status_i & MASK);
    end
    assign irq_o[l] = q;
  end
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 54,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_LINES   = 3,
  parameter int unsigned LINE_START [NUM_LINES] = '{0, 28, 46}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pad_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_PINS-1:0] cur_w, prev_w, raw_prev_w, set_w, status_w, clr_w;
  logic [NUM_PINS-1:0] en_rise_w, en_fall_w, en_high_w, en_low_w, en_arise_w, en_afall_w;

  gpio_evt_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_i),
    .cur_o(cur_w), .prev_o(prev_w), .raw_prev_o(raw_prev_w)
  );

  gpio_evt_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .pad_i(pad_i), .cur_i(cur_w), .prev_i(prev_w), .raw_prev_i(raw_prev_w),
    .en_rise_i(en_rise_w), .en_fall_i(en_fall_w), .en_high_i(en_high_w),
    .en_low_i(en_low_w), .en_arise_i(en_arise_w), .en_afall_i(en_afall_w),
    .set_o(set_w)
  );

  gpio_evt_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .set_i(set_w), .status_o(status_w), .clr_o(clr_w),
    .en_rise_o(en_rise_w), .en_fall_o(en_fall_w), .en_high_o(en_high_w),
    .en_low_o(en_low_w), .en_arise_o(en_arise_w), .en_afall_o(en_afall_w)
  );

  gpio_evt_irq #(.NUM_PINS(NUM_PINS), .NUM_LINES(NUM_LINES), .LINE_START(LINE_START)) u_irq (
    .clk(clk), .rst_n(rst_n), .status_i(status_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 54,
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned LINE0_END = 28
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [BUS_W-1:0]     bus_rdata_o,
  input logic [NUM_LINES-1:0] irq_o,
  input logic [NUM_PINS-1:0]  status,
  input logic [NUM_PINS-1:0]  set_vec,
  input logic [NUM_PINS-1:0]  clr_vec
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BUS_W - 1) / BUS_W;
  reg_sel_t sel_c;
  assign sel_c = decode_addr(bus_addr_i, NUM_BANKS);

  // R7: a set condition always lands, even against a clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R8: a set bit only drops where a clear was written
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~$past(clr_vec) & ~status) == '0));

  // R10: no bit rises without a detected condition
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

  // R9: the lowest line tracks its pin range one cycle later
  p_line0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[0] == $past(|status[LINE0_END-1:0])));

  // R9: no pending status means all lines drop next cycle
  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> (irq_o == '0));

  // R11: unmapped reads return zero
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !sel_c.hit) |=> (bus_rdata_o == '0));
endmodule

bind gpio_evt_top gpio_evt_chk #(
  .NUM_PINS(NUM_PINS), .NUM_LINES(NUM_LINES), .LINE0_END(LINE_START[1])
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .status(status_w),
  .set_vec(set_w), .clr_vec(clr_w)
);

// File: tb/test_gpio_evt_top.sv
module test_gpio_evt_top;
  localparam int unsigned NP = 54;
  localparam logic [7:0] A_ST0 = 8'h40, A_ST1 = 8'h44;
  localparam logic [7:0] A_RI0 = 8'h4C, A_RI1 = 8'h50;
  localparam logic [7:0] A_FA1 = 8'h5C;
  localparam logic [7:0] A_HI0 = 8'h64;
  localparam logic [7:0] A_LO1 = 8'h74;
  localparam logic [7:0] A_AR1 = 8'h80;
  localparam logic [7:0] A_AF1 = 8'h8C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pad = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0] irq;

  always #5 clk = ~clk;

  gpio_evt_top i_gpio_evt_top (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] q_exp[$];
  string q_tag[$];
  logic rd_seen = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: the read strobed at the last edge is due now
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && q_exp.size() > 0) check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [2:0] exp, input string tag);
    check(tag, {29'd0, irq}, {29'd0, exp});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk_irq(3'b000, "R1 irq");
    check("R1 rdata", bus_rdata, 32'h0);
    for (int k = 0; k < 7; k++)
      for (int b = 0; b < 2; b++)
        rd(8'(8'h40 + k * 12 + b * 4), 32'h0, "R1 reg");

    // R2 map and readback, R11 unmapped
    wr(A_RI0, 32'hA5A5A5A5);
    rd(A_RI0, 32'hA5A5A5A5, "R2 bank0");
    wr(A_RI1, 32'hFFFFFFFF);
    rd(A_RI1, 32'h003FFFFF, "R2 bank1 upper bits");
    wr(A_RI0, 32'h0);
    wr(A_RI1, 32'h0);
    rd(A_RI0, 32'h0, "R2 rewrite");
    rd(8'h48, 32'h0, "R11 gap");
    rd(8'h00, 32'h0, "R11 low");
    rd(8'h42, 32'h0, "R11 misaligned");

    // R3 sync rising timing on pin 3
    wr(A_RI0, 32'h8);
    pad[3] = 1'b1;
    tick();  chk_irq(3'b000, "R3 edge1");
    tick(2); chk_irq(3'b000, "R3 edge3");
    tick();  chk_irq(3'b001, "R3 edge4");
    rd(A_ST0, 32'h8, "R3 status");
    // R7 write-one-to-clear
    wr(A_ST0, 32'h0);
    rd(A_ST0, 32'h8, "R7 zero write");
    wr(A_ST0, 32'h8);
    tick(); chk_irq(3'b000, "R9 after clear");
    rd(A_ST0, 32'h0, "R7 cleared");

    // R10 unmatched edges
    pad[3] = 1'b0; pad[7] = 1'b1;
    tick(4);
    pad[7] = 1'b0;
    tick(4);
    rd(A_ST0, 32'h0, "R10 ignored");
    wr(A_RI0, 32'h0);

    // R4 both edges on pin 50 (bank1 bit 18)
    wr(A_RI1, 32'h1 << 18);
    wr(A_FA1, 32'h1 << 18);
    pad[50] = 1'b1;
    tick(5);
    chk_irq(3'b100, "R4 rise R9 line2");
    rd(A_ST1, 32'h1 << 18, "R4 rise");
    wr(A_ST1, 32'h1 << 18);
    tick();
    rd(A_ST1, 32'h0, "R4 cleared");
    pad[50] = 1'b0;
    tick(5);
    rd(A_ST1, 32'h1 << 18, "R4 fall");
    wr(A_ST1, 32'h1 << 18);
    wr(A_RI1, 32'h0);
    wr(A_FA1, 32'h0);
    tick();
    rd(A_ST1, 32'h0, "R4 end");

    // R5 high level on pin 28, R9 bank-crossing line
    pad[28] = 1'b1;
    tick(4);
    wr(A_HI0, 32'h1 << 28);
    tick(2);
    chk_irq(3'b010, "R5 R9 line1");
    rd(A_ST0, 32'h1 << 28, "R5 high");
    wr(A_ST0, 32'h1 << 28);
    tick();
    rd(A_ST0, 32'h1 << 28, "R5 relatch");
    pad[28] = 1'b0;
    tick(4);
    wr(A_ST0, 32'h1 << 28);
    tick();
    rd(A_ST0, 32'h0, "R5 high released");
    wr(A_HI0, 32'h0);

    // R5 low level on pin 45 (bank1 bit 13)
    wr(A_LO1, 32'h1 << 13);
    tick(2);
    rd(A_ST1, 32'h1 << 13, "R5 low");
    chk_irq(3'b010, "R5 low R9 line1");
    pad[45] = 1'b1;
    tick(4);
    wr(A_ST1, 32'h1 << 13);
    tick();
    rd(A_ST1, 32'h0, "R5 low released");
    wr(A_LO1, 32'h0);
    tick(3);

    // R6 async falling on pin 46 (bank1 bit 14)
    pad[46] = 1'b1;
    tick(4);
    wr(A_AF1, 32'h1 << 14);
    pad[46] = 1'b0;
    tick(); chk_irq(3'b000, "R6 edge1");
    tick(); chk_irq(3'b100, "R6 edge2");
    rd(A_ST1, 32'h1 << 14, "R6 status");

    // R8 status outlives its enable
    wr(A_AF1, 32'h0);
    tick(2);
    rd(A_ST1, 32'h1 << 14, "R8 kept");
    wr(A_ST1, 32'h1 << 14);
    tick();
    rd(A_ST1, 32'h0, "R8 cleared");

    // R7 set beats clear: async rise on pin 40 (bank1 bit 8)
    wr(A_AR1, 32'h1 << 8);
    pad[40] = 1'b1;
    wr(A_ST1, 32'h1 << 8);
    rd(A_ST1, 32'h1 << 8, "R7 set wins");
    wr(A_ST1, 32'h1 << 8);
    tick();
    rd(A_ST1, 32'h0, "R7 later clear");
    wr(A_AR1, 32'h0);

    tick(2);
    summary();
    $finish;
  end
endmodule